// File: doc/BRIEF.md
# Byte-Register Interrupt Aggregator Expander

This block is a small register-mapped expander that sits beside a host processor on an 8-bit byte bus. It watches eight external interrupt lines and records a rising edge on any of them in a pending register. The host clears pending bits by writing ones to them. A read/write enable register decides which pending bits reach one active-high interrupt line to the host, and a level register shows the synchronized state of the lines. Source bit 2 is reserved: it never becomes pending.

The block also drives five byte-wide control outputs. Four of them sit at offsets 0x00, 0x02, 0x04 and 0x06 and can only be written. Their readback is unspecified, so software must keep its own copy of them. The fifth control register, at offset 0x0A, reads back what was last written, which lets software do read-modify-write on it. Register state is held until reset.

Writes take effect on a one-cycle `wr_en` strobe. A read returns data in the same cycle the address is presented, with no clock edge in between.

Top module: `irq_expander`

## Requirements
- R1: After reset the pending register (offset 0x0E) and the enable register (offset 0x0C) read 0x00 and `irq_out` is low. `ctl_q` holds 0x80 in bits [7:0], 0x34 in [15:8], 0x00 in [23:16], 0x04 in [31:24] and 0x00 in [39:32].
- R2: A 0-to-1 transition on `irq_in[i]` sets pending bit i three clock edges after the change: two synchronizer edges, then the setting edge. This happens whether or not bit i is enabled.
- R3: A write to offset 0x0E clears every pending bit written as 1. Bits written as 0 keep their value.
- R4: The enable register at offset 0x0C reads back the last value written to it. A 1 enables that source.
- R5: `irq_out` is high exactly when some pending bit has its enable bit set. It is low whenever the enable register is 0x00.
- R6: Offset 0x08 reads the synchronized level of all eight `irq_in` lines, including bit 2.
- R7: Pending bit 2 is never set, whatever `irq_in[2]` does.
- R8: When a rising edge of bit i and a clearing write of bit i reach the same clock edge, pending bit i ends up set.
- R9: A write to offset 0x0A updates `ctl_q[39:32]`, and reading 0x0A returns that value.
- R10: A write to offset 0x00, 0x02, 0x04 or 0x06 updates `ctl_q[7:0]`, `[15:8]`, `[23:16]` or `[31:24]` respectively. The value read from these offsets is unspecified.
- R11: A line held high sets its pending bit only once. After that bit is cleared it stays clear until the line falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Byte register offset |
| wr_en | input | 1 | One-cycle write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq_in | input | 8 | External interrupt lines, asynchronous |
| irq_out | output | 1 | Active-high combined interrupt to the host |
| ctl_q | output | 40 | Five control bytes, offset 0x00 in the low byte through offset 0x0A in the high byte |

## Verification
A new edge on a source can set its pending bit on the same clock edge that a host write clears that bit. The bench makes this happen on purpose. It first leaves a bit pending, then drops and raises that line. It times the raise so the synchronized edge is seen during the exact cycle in which the clearing write is strobed. The pending bit must read 1 afterwards. A second clearing write, with no edge alongside it, must then bring the bit to 0, which shows that the clear itself works.

// File: rtl/irq_exp_pkg.sv
package irq_exp_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 4;
    localparam int NUM_CTL = 5;
    localparam int RSV_BIT = 2;

    localparam logic [ADDR_W-1:0] OFS_STAT   = 4'hE;
    localparam logic [ADDR_W-1:0] OFS_LVL    = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 4'hC;
    localparam logic [ADDR_W-1:0] OFS_CTL_RW = 4'hA;

    // sources that may become pending (reserved bit removed)
    localparam logic [DATA_W-1:0] SRC_USE = ~(DATA_W'(1) << RSV_BIT);

    // reset values of the control bytes, index 0 lives at offset 0x00
    localparam logic [NUM_CTL-1:0][DATA_W-1:0] CTL_RST =
        {8'h00, 8'h04, 8'h00, 8'h34, 8'h80};

    typedef struct packed {
        logic               stat;
        logic               lvl;
        logic               mask;
        logic [NUM_CTL-1:0] ctl;
    } reg_hit_t;

    typedef enum logic [2:0] {
        RD_ZERO,
        RD_STAT,
        RD_LVL,
        RD_MASK,
        RD_CTL_RW
    } rd_src_e;

    // the write-only bytes sit on even offsets 0,2,4,...; the last one is readable
    function automatic reg_hit_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_hit_t h;
        h      = '0;
        h.stat = (a == OFS_STAT);
        h.lvl  = (a == OFS_LVL);
        h.mask = (a == OFS_MASK);
        for (int k = 0; k < NUM_CTL - 1; k++) begin
            h.ctl[k] = (a == ADDR_W'(2 * k));
        end
        h.ctl[NUM_CTL-1] = (a == OFS_CTL_RW);
        return h;
    endfunction

    function automatic rd_src_e pick_read(input reg_hit_t h);
        rd_src_e s;
        s = RD_ZERO;
        if (h.stat)              s = RD_STAT;
        else if (h.lvl)          s = RD_LVL;
        else if (h.mask)         s = RD_MASK;
        else if (h.ctl[NUM_CTL-1]) s = RD_CTL_RW;
        return s;
    endfunction

endpackage

// File: rtl/irq_exp_sync.sv
module irq_exp_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= '0;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_exp_capture.sv
module irq_exp_capture #(
    parameter int           W   = 8,
    parameter logic [W-1:0] USE = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] status_q,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;
    logic [W-1:0] stat_nxt;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q & USE;

    // clear first, then set: a new edge outranks a clear in the same cycle
    always_comb begin
        stat_nxt = status_q;
        if (clr_en) stat_nxt = stat_nxt & ~clr_bits;
        stat_nxt = stat_nxt | rise;
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= stat_nxt;
    end
endmodule

// File: rtl/irq_exp_regs.sv
module irq_exp_regs #(
    parameter int                    W   = 8,
    parameter int                    N   = 5,
    parameter logic [N-1:0][W-1:0]   RST = '0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   wdata,
    input  logic           mask_we,
    input  logic [N-1:0]   ctl_we,
    output logic [W-1:0]   mask_q,
    output logic [N*W-1:0] ctl_q
);
    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (mask_we) mask_q <= wdata;
    end

    for (genvar k = 0; k < N; k++) begin : g_ctl
        always_ff @(posedge clk) begin
            if (rst)            ctl_q[k*W +: W] <= RST[k];
            else if (ctl_we[k]) ctl_q[k*W +: W] <= wdata;
        end
    end
endmodule

// File: rtl/irq_expander.sv
module irq_expander
    import irq_exp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      wr_en,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata,
    input  logic [DATA_W-1:0]         irq_in,
    output logic                      irq_out,
    output logic [NUM_CTL*DATA_W-1:0] ctl_q
);
    reg_hit_t          hit;
    rd_src_e           rsel;
    logic [DATA_W-1:0] lvl_sync;
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] rise;
    logic [DATA_W-1:0] mask_q;

    assign hit  = decode_addr(addr);
    assign rsel = pick_read(hit);

    irq_exp_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (irq_in),
        .q   (lvl_sync)
    );

    irq_exp_capture #(.W(DATA_W), .USE(SRC_USE)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .lvl      (lvl_sync),
        .clr_en   (wr_en & hit.stat),
        .clr_bits (wdata),
        .status_q (status_q),
        .rise     (rise)
    );

    irq_exp_regs #(.W(DATA_W), .N(NUM_CTL), .RST(CTL_RST)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wdata   (wdata),
        .mask_we (wr_en & hit.mask),
        .ctl_we  ({NUM_CTL{wr_en}} & hit.ctl),
        .mask_q  (mask_q),
        .ctl_q   (ctl_q)
    );

    assign irq_out = |(status_q & mask_q);

    always_comb begin
        unique case (rsel)
            RD_STAT:   rdata = status_q;
            RD_LVL:    rdata = lvl_sync;
            RD_MASK:   rdata = mask_q;
            RD_CTL_RW: rdata = ctl_q[NUM_CTL*DATA_W-1 -: DATA_W];
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_expander_chk.sv
module irq_expander_chk
    import irq_exp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wdata,
    input logic              irq_out,
    input logic [DATA_W-1:0] status_q,
    input logic [DATA_W-1:0] rise,
    input logic [DATA_W-1:0] mask_q,
    input logic [DATA_W-1:0] ctl_lo,
    input logic [DATA_W-1:0] ctl_rw
);
    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((status_q & $past(rise)) == $past(rise)));

    // R3
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_STAT) |=> ((status_q & $past(wdata & ~rise)) == '0));

    // R7
    rsv_bit_chk: assert property (@(posedge clk) disable iff (rst)
        !status_q[RSV_BIT]);

    // R4
    mask_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_MASK) |=> (mask_q == $past(wdata)));

    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (mask_q != '0 && status_q != '0));

    // R9
    ctl_rw_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_CTL_RW) |=> (ctl_rw == $past(wdata)));

    // R10
    ctl_wo_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 4'h0) |=> (ctl_lo == $past(wdata)));
endmodule

bind irq_expander irq_expander_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .irq_out  (irq_out),
    .status_q (status_q),
    .rise     (rise),
    .mask_q   (mask_q),
    .ctl_lo   (ctl_q[7:0]),
    .ctl_rw   (ctl_q[39:32])
);

// File: tb/tb_irq_expander.sv
`timescale 1ns/1ps
module tb_irq_expander;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = 4'h0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic [7:0]  irq_in = 8'h00;
    logic        irq_out;
    logic [39:0] ctl_q;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    irq_expander dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .irq_in(irq_in), .irq_out(irq_out), .ctl_q(ctl_q)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        irq_in = 8'h00;
        @(negedge clk); rst = 1'b1; wr_en = 1'b0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic drive_in(input logic [7:0] v);
        @(negedge clk); irq_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        bus_read(4'hE, d); check("R1 pending", d, 8'h00);
        bus_read(4'hC, d); check("R1 enable", d, 8'h00);
        check("R1 irq_out", irq_out, 1'b0);
        check("R1 ctl defaults", ctl_q, 40'h00_04_00_34_80);
    endtask

    task automatic t_edge_and_gate();
        logic [7:0] d;
        do_reset();
        drive_in(8'h01);
        bus_read(4'hE, d); check("R2 masked edge sets", d, 8'h01);
        check("R5 low when disabled", irq_out, 1'b0);
        bus_write(4'hC, 8'h01);
        check("R5 high when enabled", irq_out, 1'b1);
        bus_write(4'hC, 8'h02);
        check("R5 other bit enabled only", irq_out, 1'b0);
    endtask

    task automatic t_clear_and_hold();
        logic [7:0] d;
        do_reset();
        bus_write(4'hC, 8'hFF);
        drive_in(8'h09);
        bus_read(4'hE, d); check("R2 two edges", d, 8'h09);
        bus_write(4'hE, 8'h08);
        bus_read(4'hE, d); check("R3 partial clear", d, 8'h01);
        check("R5 still pending", irq_out, 1'b1);
        bus_write(4'hE, 8'h01);
        bus_read(4'hE, d); check("R3 full clear", d, 8'h00);
        check("R5 nothing pending", irq_out, 1'b0);
        repeat (5) @(negedge clk);
        bus_read(4'hE, d); check("R11 held line no re-set", d, 8'h00);
        drive_in(8'h00);
        drive_in(8'h01);
        bus_read(4'hE, d); check("R11 new edge re-sets", d, 8'h01);
    endtask

    task automatic t_mask_level_rsv();
        logic [7:0] d;
        do_reset();
        bus_write(4'hC, 8'h6D);
        bus_read(4'hC, d); check("R4 enable readback", d, 8'h6D);
        drive_in(8'hA5);
        bus_read(4'h8, d); check("R6 level A5", d, 8'hA5);
        drive_in(8'h00);
        bus_read(4'h8, d); check("R6 level 00", d, 8'h00);
        bus_write(4'hE, 8'hFF);
        drive_in(8'hFF);
        bus_read(4'hE, d); check("R7 reserved bit stays clear", d, 8'hFB);
        bus_read(4'h8, d); check("R6 level FF", d, 8'hFF);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        do_reset();
        bus_write(4'hC, 8'hFF);
        drive_in(8'h02);
        drive_in(8'h00);
        bus_read(4'hE, d); check("R8 precondition", d, 8'h02);
        @(negedge clk); irq_in = 8'h02;
        @(negedge clk);
        @(negedge clk); addr = 4'hE; wdata = 8'h02; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        bus_read(4'hE, d); check("R8 set beats clear", d, 8'h02);
        bus_write(4'hE, 8'h02);
        bus_read(4'hE, d); check("R3 clear without edge", d, 8'h00);
    endtask

    task automatic t_ctl();
        logic [7:0] d;
        do_reset();
        bus_write(4'h2, 8'h5A);
        check("R10 byte at 0x02", ctl_q, 40'h00_04_00_5A_80);
        bus_write(4'h6, 8'h11);
        check("R10 byte at 0x06", ctl_q, 40'h00_11_00_5A_80);
        bus_write(4'hA, 8'hC3);
        bus_read(4'hA, d); check("R9 readback", d, 8'hC3);
        check("R9 output byte", ctl_q[39:32], 8'hC3);
        bus_write(4'hA, 8'h3C);
        bus_read(4'hA, d); check("R9 second readback", d, 8'h3C);
    endtask

    initial begin
        t_reset();
        t_edge_and_gate();
        t_clear_and_hold();
        t_mask_level_rsv();
        t_collide();
        t_ctl();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule